// File: doc/BRIEF.md
# Chained-XOR Modulo-3 Memory Self-Test Engine

This block tests a region of a synchronous, word-wide RAM with very little checking logic. It writes a three-phase rotating bit pattern over the region. It then makes two chaining walks over it. In each walk it reads every word, XORs in the word before it, and writes the result back. A read or write fault in one word therefore changes every word that comes after it in the walk. Only the three words at the far end of the walk are compared against expected values. Those differences are collected into a bad-bit mask.

A controller gives a start word address, an end word address (the region is start to end−1), a direction, and a one-cycle start pulse. The engine raises busy while it runs and pulses done when it finishes. It then holds the mask until the next start. The RAM port is a single port with a read latency fixed by a parameter. The block issues at most one read or write per cycle. A region shorter than six words is refused: no memory access is made and the error flag is raised.

Top module: `mbist_mod3`

## Requirements
- R1: Fill: with N = end_addr − start_addr words and walk index k = 0..N−1, word k receives pattern P[k mod 3]. P0 has a 0 at every bit i with i mod 3 = 1 and a 1 elsewhere (32'h6DB6DB6D at 32 bits). P1 has its zeros at i mod 3 = 0 (32'hB6DB6DB6). P2 has its zeros at i mod 3 = 2 (32'hDB6DB6DB). Walk index k maps to address start_addr+k when ascending and to end_addr−1−k when descending. Every access falls inside the region.
- R2: Chaining: in each walk, word 0 is XORed with a seed pattern. Then, for k ≥ 1, word k−1 is read back from memory and XORed into word k. On fault-free memory the region finally holds P[(k+1) mod 3] at walk index k.
- R3: Exactly two chaining walks are made, seeded with P1 first and P0 second. A valid run makes 3N writes and 4N+1 reads.
- R4: Ascending runs compare the words at walk index N−3, N−2 and N−1 against P[(k+1) mod 3]. On fault-free memory the mask is zero whatever N mod 3 is.
- R5: Descending runs fill and chain from end_addr−1 downward, so the three lowest words of the region are the ones compared. On fault-free memory the mask is zero.
- R6: With stuck-at bits in the memory, the mask equals the OR of the XOR differences on the three compared words. A word stuck entirely at one value gives a nonzero mask.
- R7: If N < 6, or end_addr < start_addr, the engine pulses done with err_short = 1 and a zero mask, and makes no memory access. err_short holds until the next accepted start.
- R8: The mask is cleared when a start is accepted. It holds its value after done until the next accepted start. done is a one-cycle pulse during which busy is low.
- R9: busy is high from the cycle after an accepted start through the last memory access. mem_we and mem_re are never high together, and neither is high while busy is low.
- R10: A start pulse while busy or done is high is ignored; the run in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| descend | input | 1 | 1 = walk from the top of the region downward |
| start_addr | input | AW | First word address of the region |
| end_addr | input | AW | Word address one past the region |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| err_short | output | 1 | Last request was shorter than six words |
| bad_mask | output | DW | Accumulated bad-bit mask |
| mem_addr | output | AW | RAM word address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | DW | RAM write data |
| mem_re | output | 1 | RAM read enable |
| mem_rdata | input | DW | RAM read data, valid RD_LAT cycles after mem_re |

## Verification
The bench builds the engine with AW = 6, DW = 32 and RD_LAT = 2. This gives a 64-word behavioural RAM, and a read latency above one exercises the multi-cycle wait path. It sweeps every length from 0 to 13 words in both directions. That covers all three length residues modulo 3, the six-word boundary and the refused short lengths. A reference model in the bench runs the same fill-and-chain sequence on a copy of the memory that carries the same stuck-at faults. Fault runs place stuck words at the start, the middle and inside the compared window.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_FILL,
      S_PREV,
      S_PREV_W,
      S_CUR,
      S_CUR_W,
      S_WR,
      S_CHK,
      S_CHK_W,
      S_FIN
   } mbist_state_t;

   localparam int MIN_REGION_WORDS = 6;
   localparam int CHECK_WORDS      = 3;

   function automatic logic [1:0] phase_next(input logic [1:0] p);
      return (p == 2'd2) ? 2'd0 : p + 2'd1;
   endfunction

endpackage

// File: rtl/mbist_pattern.sv
module mbist_pattern #(
   parameter int DW = 32
) (
   input  logic [1:0]    phase,
   output logic [DW-1:0] pat
);
   // bit i is zero in the one phase for which (i + phase) mod 3 == 1
   for (genvar i = 0; i < DW; i++) begin : g_bit
      localparam logic [1:0] ZERO_PH = 2'((4 - (i % 3)) % 3);
      assign pat[i] = (phase != ZERO_PH);
   end
endmodule

// File: rtl/mbist_addr.sv
module mbist_addr #(
   parameter int AW = 10,
   parameter int IW = AW + 1
) (
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   input  logic          desc,
   input  logic [IW-1:0] idx,
   output logic [AW-1:0] addr
);
   logic [IW-1:0] up_a;
   logic [IW-1:0] dn_a;

   assign up_a = {1'b0, lo} + idx;
   assign dn_a = {1'b0, hi} - IW'(1) - idx;
   assign addr = desc ? dn_a[AW-1:0] : up_a[AW-1:0];
endmodule

// File: rtl/mbist_rdwait.sv
module mbist_rdwait #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   output logic hit
);
   if (LAT == 1) begin : g_one
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= issue;
      end
      assign hit = q;
   end else begin : g_cnt
      localparam int CW = $clog2(LAT + 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  cnt <= '0;
         else if (issue)              cnt <= CW'(1);
         else if (cnt == CW'(LAT))    cnt <= '0;
         else if (cnt != '0)          cnt <= cnt + CW'(1);
      end
      assign hit = (cnt == CW'(LAT));
   end
endmodule

// File: rtl/mbist_mod3.sv
module mbist_mod3
   import mbist_pkg::*;
#(
   parameter int AW     = 10,
   parameter int DW     = 32,
   parameter int RD_LAT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          descend,
   input  logic [AW-1:0] start_addr,
   input  logic [AW-1:0] end_addr,
   output logic          busy,
   output logic          done,
   output logic          err_short,
   output logic [DW-1:0] bad_mask,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_re,
   input  logic [DW-1:0] mem_rdata
);
   localparam int IW = AW + 1;
   localparam logic [IW-1:0] MIN_N  = IW'(MIN_REGION_WORDS);
   localparam logic [IW-1:0] N_CHK  = IW'(CHECK_WORDS);

   if (AW < 3)     begin : g_bad_aw  $error("AW must allow six words"); end
   if (DW < 3)     begin : g_bad_dw  $error("DW must hold a full pattern period"); end
   if (RD_LAT < 1) begin : g_bad_lat $error("RD_LAT must be at least one"); end

   mbist_state_t  state_q;
   logic [AW-1:0] lo_q, hi_q;
   logic          desc_q;
   logic [IW-1:0] nw_q, idx_q, idx_sel;
   logic [1:0]    phase_q, nmod3_q, pat_ph, chk_n_q;
   logic          pass_q, err_q, rd_hit;
   logic [DW-1:0] prev_q, cur_q, mask_q, pat;
   logic [IW-1:0] span;
   logic          too_short, last_word;

   assign span      = {1'b0, end_addr} - {1'b0, start_addr};
   assign too_short = span[AW] | (span < MIN_N);
   assign last_word = (idx_q == nw_q - IW'(1));

   mbist_pattern #(.DW(DW)) u_pat (
      .phase (pat_ph),
      .pat   (pat)
   );

   mbist_addr #(.AW(AW), .IW(IW)) u_addr (
      .lo   (lo_q),
      .hi   (hi_q),
      .desc (desc_q),
      .idx  (idx_sel),
      .addr (mem_addr)
   );

   mbist_rdwait #(.LAT(RD_LAT)) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .issue (mem_re),
      .hit   (rd_hit)
   );

   always_comb begin
      pat_ph    = phase_q;
      idx_sel   = idx_q;
      mem_we    = 1'b0;
      mem_re    = 1'b0;
      mem_wdata = pat;
      unique case (state_q)
         S_FILL: mem_we = 1'b1;
         S_PREV: begin
            pat_ph = pass_q ? 2'd0 : 2'd1;
            if (idx_q != '0) begin
               mem_re  = 1'b1;
               idx_sel = idx_q - IW'(1);
            end
         end
         S_CUR, S_CHK: mem_re = 1'b1;
         S_WR: begin
            mem_we    = 1'b1;
            mem_wdata = cur_q ^ prev_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         lo_q    <= '0;
         hi_q    <= '0;
         desc_q  <= 1'b0;
         nw_q    <= '0;
         idx_q   <= '0;
         phase_q <= 2'd0;
         nmod3_q <= 2'd0;
         chk_n_q <= 2'd0;
         pass_q  <= 1'b0;
         err_q   <= 1'b0;
         prev_q  <= '0;
         cur_q   <= '0;
         mask_q  <= '0;
      end else begin
         unique case (state_q)
            S_IDLE: if (start) begin
               lo_q    <= start_addr;
               hi_q    <= end_addr;
               desc_q  <= descend;
               nw_q    <= span;
               idx_q   <= '0;
               phase_q <= 2'd0;
               pass_q  <= 1'b0;
               mask_q  <= '0;
               err_q   <= too_short;
               state_q <= too_short ? S_FIN : S_FILL;
            end
            S_FILL: begin
               phase_q <= phase_next(phase_q);
               if (last_word) begin
                  nmod3_q <= phase_next(phase_q);
                  idx_q   <= '0;
                  state_q <= S_PREV;
               end else begin
                  idx_q <= idx_q + IW'(1);
               end
            end
            S_PREV: begin
               if (idx_q == '0) begin
                  prev_q  <= pat;
                  state_q <= S_CUR;
               end else begin
                  state_q <= S_PREV_W;
               end
            end
            S_PREV_W: if (rd_hit) begin
               prev_q  <= mem_rdata;
               state_q <= S_CUR;
            end
            S_CUR: state_q <= S_CUR_W;
            S_CUR_W: if (rd_hit) begin
               cur_q   <= mem_rdata;
               state_q <= S_WR;
            end
            S_WR: begin
               if (!last_word) begin
                  idx_q   <= idx_q + IW'(1);
                  state_q <= S_PREV;
               end else if (!pass_q) begin
                  pass_q  <= 1'b1;
                  idx_q   <= '0;
                  state_q <= S_PREV;
               end else begin
                  idx_q   <= nw_q - N_CHK;
                  phase_q <= phase_next(nmod3_q);
                  chk_n_q <= 2'd0;
                  state_q <= S_CHK;
               end
            end
            S_CHK: state_q <= S_CHK_W;
            S_CHK_W: if (rd_hit) begin
               mask_q  <= mask_q | (mem_rdata ^ pat);
               phase_q <= phase_next(phase_q);
               idx_q   <= idx_q + IW'(1);
               if (chk_n_q == 2'(CHECK_WORDS - 1)) begin
                  state_q <= S_FIN;
               end else begin
                  chk_n_q <= chk_n_q + 2'd1;
                  state_q <= S_CHK;
               end
            end
            S_FIN: state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != S_IDLE) && (state_q != S_FIN);
   assign done      = (state_q == S_FIN);
   assign err_short = err_q;
   assign bad_mask  = mask_q;

endmodule

// File: rtl/mbist_mod3_chk.sv
module mbist_mod3_chk #(
   parameter int AW = 10,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [AW-1:0] start_addr,
   input logic [AW-1:0] end_addr,
   input logic          busy,
   input logic          done,
   input logic          err_short,
   input logic [DW-1:0] bad_mask,
   input logic [AW-1:0] mem_addr,
   input logic          mem_we,
   input logic          mem_re
);
   logic          accept;
   logic [AW-1:0] lo_c, hi_c;

   assign accept = start && !busy && !done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_c <= '0;
         hi_c <= '0;
      end else if (accept) begin
         lo_c <= start_addr;
         hi_c <= end_addr;
      end
   end

   p_addr_in_region_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> (mem_addr >= lo_c && mem_addr < hi_c));

   p_single_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   p_quiet_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_we && !mem_re));

   p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_mask_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (bad_mask == '0));

   p_mask_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !accept) |=> $stable(bad_mask));

   p_short_never_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_short |-> !busy);

endmodule

bind mbist_mod3 mbist_mod3_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .start_addr (start_addr),
   .end_addr   (end_addr),
   .busy       (busy),
   .done       (done),
   .err_short  (err_short),
   .bad_mask   (bad_mask),
   .mem_addr   (mem_addr),
   .mem_we     (mem_we),
   .mem_re     (mem_re)
);

// File: tb/mbist_mod3_test.sv
`timescale 1ns/1ps
module mbist_mod3_test;
   localparam int AW    = 6;
   localparam int DW    = 32;
   localparam int LAT   = 2;
   localparam int WORDS = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          descend = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [AW-1:0] end_addr = '0;
   logic          busy, done, err_short;
   logic [DW-1:0] bad_mask;
   logic [AW-1:0] mem_addr;
   logic          mem_we, mem_re;
   logic [DW-1:0] mem_wdata, mem_rdata;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   mbist_mod3 #(.AW(AW), .DW(DW), .RD_LAT(LAT)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .descend(descend),
      .start_addr(start_addr), .end_addr(end_addr),
      .busy(busy), .done(done), .err_short(err_short), .bad_mask(bad_mask),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_re(mem_re), .mem_rdata(mem_rdata)
   );

   // behavioural RAM with stuck-at masks and fixed read latency
   logic [DW-1:0] ram  [WORDS];
   logic [DW-1:0] st0  [WORDS];
   logic [DW-1:0] st1  [WORDS];
   logic [DW-1:0] pipe [LAT];
   logic [DW-1:0] wr_log [64];
   int wr_cnt = 0;
   int rd_cnt = 0;
   int log_base = 0;

   always @(posedge clk) begin
      pipe[0] <= ram[mem_addr];
      for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
      if (mem_we) begin
         ram[mem_addr] <= (mem_wdata & ~st0[mem_addr]) | st1[mem_addr];
         if (wr_cnt - log_base < 64 && wr_cnt >= log_base) wr_log[wr_cnt - log_base] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      if (mem_re) rd_cnt <= rd_cnt + 1;
   end
   assign mem_rdata = pipe[LAT-1];

   function automatic logic [31:0] pw(input int j);
      case (j % 3)
         0:       return 32'h6DB6DB6D;
         1:       return 32'hB6DB6DB6;
         default: return 32'hDB6DB6DB;
      endcase
   endfunction

   function automatic int wa(input int lo, input int n, input bit desc, input int k);
      return desc ? lo + n - 1 - k : lo + k;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic ref_mask(input int lo, input int n, input bit desc, output logic [31:0] m);
      logic [31:0] mdl [WORDS];
      logic [31:0] prev, cur, v;
      int a;
      for (int k = 0; k < n; k++) begin
         a = wa(lo, n, desc, k);
         mdl[a] = (pw(k) & ~st0[a]) | st1[a];
      end
      for (int p = 0; p < 2; p++) begin
         for (int k = 0; k < n; k++) begin
            a = wa(lo, n, desc, k);
            prev = (k == 0) ? ((p == 0) ? pw(1) : pw(0)) : mdl[wa(lo, n, desc, k-1)];
            cur = mdl[a];
            v = cur ^ prev;
            mdl[a] = (v & ~st0[a]) | st1[a];
         end
      end
      m = '0;
      for (int k = n - 3; k < n; k++) m |= mdl[wa(lo, n, desc, k)] ^ pw(k + 1);
   endtask

   task automatic run(input int lo, input int hi, input bit desc, input bit poke,
                      output logic [31:0] m, output logic e, output int nw, output int nr,
                      output logic b1, output logic [31:0] m1);
      int w0, r0, t;
      w0 = wr_cnt; r0 = rd_cnt;
      @(negedge clk);
      log_base = wr_cnt;
      start_addr = AW'(lo); end_addr = AW'(hi); descend = desc; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      b1 = busy; m1 = bad_mask;
      if (poke) begin
         for (int i = 0; i < 10 && !done; i++) @(negedge clk);
         start_addr = '0; end_addr = AW'(63); descend = !desc; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      t = 0;
      while (!done && t < 5000) begin
         @(negedge clk);
         t++;
      end
      check(done, "R8 done seen", 32'(done), 32'h1);
      m = bad_mask; e = err_short;
      nw = wr_cnt - w0; nr = rd_cnt - r0;
   endtask

   task automatic clean_checks(input int lo, input int n, input bit desc,
                               input logic [31:0] m, input logic e, input int nw, input int nr, input logic b1);
      bit ok;
      check(e == 1'b0, "R7 no short flag", 32'(e), 32'h0);
      check(m == '0, desc ? "R5 descending mask" : "R4 ascending mask", m, 32'h0);
      check(nw == 3*n, "R3 write count", 32'(nw), 32'(3*n));
      check(nr == 4*n + 1, "R3 read count", 32'(nr), 32'(4*n + 1));
      check(b1 == 1'b1, "R9 busy after start", 32'(b1), 32'h1);
      ok = 1'b1;
      for (int k = 0; k < n; k++) if (wr_log[k] !== pw(k)) ok = 1'b0;
      check(ok, "R1 fill pattern order", 32'(ok), 32'h1);
      ok = 1'b1;
      for (int k = 0; k < n; k++) if (ram[wa(lo, n, desc, k)] !== pw(k + 1)) ok = 1'b0;
      check(ok, "R2 final region contents", 32'(ok), 32'h1);
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
   end

   initial begin
      logic [31:0] m, m1, rm;
      logic e, b1;
      int nw, nr, lo;

      for (int i = 0; i < WORDS; i++) begin st0[i] = '0; st1[i] = '0; end
      repeat (3) @(negedge clk);
      check(!busy && !done && bad_mask == '0 && !err_short && !mem_we && !mem_re,
            "R9 reset state", {busy, done, err_short, mem_we, mem_re}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int d = 0; d < 2; d++) begin
         for (int n = 0; n < 14; n++) begin
            lo = 3 + n;
            run(lo, lo + n, bit'(d), 1'b0, m, e, nw, nr, b1, m1);
            if (n < 6) begin
               check(e == 1'b1, "R7 short flag", 32'(e), 32'h1);
               check(nw + nr == 0, "R7 no accesses", 32'(nw + nr), 32'h0);
               check(m == '0, "R7 zero mask", m, 32'h0);
               check(b1 == 1'b0, "R7 never busy", 32'(b1), 32'h0);
            end else begin
               clean_checks(lo, n, bit'(d), m, e, nw, nr, b1);
            end
         end
      end

      // reversed bounds
      run(20, 10, 1'b0, 1'b0, m, e, nw, nr, b1, m1);
      check(e == 1'b1 && nw + nr == 0, "R7 reversed region", {e, 8'(nw + nr)}, 32'h100);

      // done is a single pulse
      @(negedge clk);
      check(done == 1'b0, "R8 done one cycle", 32'(done), 32'h0);

      // start while busy is ignored
      run(5, 25, 1'b0, 1'b1, m, e, nw, nr, b1, m1);
      clean_checks(5, 20, 1'b0, m, e, nw, nr, b1);
      check(nw == 60, "R10 busy start ignored", 32'(nw), 32'd60);

      // stuck-at faults
      st1[7] = '1;
      ref_mask(2, 12, 1'b0, rm);
      run(2, 14, 1'b0, 1'b0, m, e, nw, nr, b1, m1);
      check(m == rm, "R6 mid word stuck-1 mask", m, rm);
      check(m != '0, "R6 mid word stuck-1 nonzero", m, rm);
      st1[7] = '0;

      st0[10] = '1;
      ref_mask(10, 16, 1'b1, rm);
      run(10, 26, 1'b1, 1'b0, m, e, nw, nr, b1, m1);
      check(m == rm, "R6 checked word stuck-0 mask", m, rm);
      check(m != '0, "R6 checked word stuck-0 nonzero", m, rm);
      st0[10] = '0;

      st1[30] = 32'h0000_0001;
      ref_mask(30, 9, 1'b0, rm);
      run(30, 39, 1'b0, 1'b0, m, e, nw, nr, b1, m1);
      check(m == rm, "R6 single bit stuck-1 mask", m, rm);
      st1[30] = '0;

      st0[53] = 32'hFFFF_0000;
      ref_mask(40, 14, 1'b1, rm);
      run(40, 54, 1'b1, 1'b0, m, e, nw, nr, b1, m1);
      check(m == rm, "R6 first walk word stuck-0 mask", m, rm);
      check(m != '0, "R6 first walk word stuck-0 nonzero", m, rm);
      st0[53] = '0;

      // mask holds after done, clears on next start
      repeat (20) @(negedge clk);
      check(bad_mask == m, "R8 mask held after done", bad_mask, m);
      run(40, 54, 1'b1, 1'b0, m, e, nw, nr, b1, m1);
      check(m1 == '0, "R8 mask cleared on start", m1, 32'h0);
      clean_checks(40, 14, 1'b1, m, e, nw, nr, b1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule